// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator. The accumulator is kept as a high word and a low word, and the value it holds is the concatenation {high, low} in two's complement. The unit has two product widths. The long form multiplies the full 32-bit operands. The word form multiplies only the low 16 bits of each operand.

A saturation input selects how the sum is written back. With saturation off, both forms store the exact 64-bit sum, wrapping modulo 2^64. With saturation on, the two forms clamp differently. The long form clamps only the upper bits of the high word, and the choice depends on the sign of the sum. The word form clamps the sum to the signed 32-bit range and writes 1 into the high word as an overflow marker.

Each operation takes two clock edges. The first edge registers the product. The second edge adds it into the accumulator and raises a one-cycle done pulse. A clear command empties the accumulator.

Top module: `sat_mac_unit`

## Requirements
- R1: While reset is asserted, acc_hi and acc_lo are 0 and op_done is 0.
- R2: With op_word=0 (long form) and op_sat=0, the product op_a*op_b of the two sign-extended 32-bit operands is added to {acc_hi, acc_lo}, and the full 64-bit sum is stored, wrapping modulo 2^64.
- R3: With op_word=1 (word form) and op_sat=0, only bits 15:0 of each operand are used, sign-extended. Bits 31:16 have no effect, and the full 64-bit sum is stored.
- R4: In the long form with op_sat=1, the low word receives the low 32 bits of the sum. If the 64-bit sum is negative, the high word receives the sum's high 32 bits with bits 31:16 forced to 1. Otherwise it receives them with bits 31:15 forced to 0.
- R5: In the word form with op_sat=1, a sum above 2^31-1 stores acc_hi=0x00000001 and acc_lo=0x7FFFFFFF.
- R6: In the word form with op_sat=1, a sum below -2^31 stores acc_hi=0x00000001 and acc_lo=0x80000000. A sum from -2^31 to 2^31-1, limits included, is stored unchanged.
- R7: Suppose op_start is high at a rising edge while the unit is idle and acc_clear is low. The accumulator then takes its new value at the following rising edge, and op_done is high for exactly that one cycle.
- R8: An op_start sampled at the edge right after an accepted start is ignored: it produces no product and no done pulse.
- R9: acc_clear high at a rising edge zeroes both words at that edge. It takes priority over an op_start in the same cycle. It also discards an operation still waiting for its accumulate edge, so that operation produces no done pulse.
- R10: At any edge without an accumulate or a clear, acc_hi and acc_lo keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | Start strobe for one operation |
| op_word | input | 1 | 0 = long form (32x32), 1 = word form (16x16) |
| op_sat | input | 1 | Enables saturation on write-back |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| acc_clear | input | 1 | Zeroes the accumulator; overrides start |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |
| op_done | output | 1 | One-cycle pulse when the accumulator updates |

## Verification
The accumulator feeds back into every later sum. A wrong stored value, a stale product register or a wrong saturation choice therefore shows at the ports on the edge of the faulty update, and the error persists through all later results. A mistake in the busy or cancel logic shows within one cycle, either as a done pulse that should not occur or as a missing one. The outputs are compared against the model on every clock. Directed cases sit on both word-form limits, exactly at each limit, and on long-form sums of -1 and 0 with saturation on.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  localparam int unsigned MAC_DW = 32;
  localparam int unsigned MAC_AW = 2 * MAC_DW;
  localparam int unsigned MAC_HW = MAC_DW / 2;

  typedef logic [MAC_DW-1:0]        word_t;
  typedef logic signed [MAC_AW-1:0] acc_t;

  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } mac_mode_e;

  typedef struct packed {
    logic      valid;
    mac_mode_e mode;
    logic      sat;
    acc_t      prod;
  } stage_t;

  localparam acc_t WORD_MAX = {{(MAC_AW-MAC_DW+1){1'b0}}, {(MAC_DW-1){1'b1}}};
  localparam acc_t WORD_MIN = ~WORD_MAX;
  localparam acc_t WORD_POS_CLAMP = {{(MAC_DW-1){1'b0}}, 1'b1, 1'b0, {(MAC_DW-1){1'b1}}};
  localparam acc_t WORD_NEG_CLAMP = {{(MAC_DW-1){1'b0}}, 1'b1, 1'b1, {(MAC_DW-1){1'b0}}};

  // Widen an operand to the accumulator width with sign extension.
  function automatic acc_t sext_full(input word_t v);
    return {{(MAC_AW-MAC_DW){v[MAC_DW-1]}}, v};
  endfunction

  function automatic acc_t sext_half(input word_t v);
    return {{(MAC_AW-MAC_HW){v[MAC_HW-1]}}, v[MAC_HW-1:0]};
  endfunction

  // Signed product for the selected form.
  function automatic acc_t mac_product(input mac_mode_e m, input word_t a, input word_t b);
    acc_t ea;
    acc_t eb;
    if (m == MODE_WORD) begin
      ea = sext_half(a);
      eb = sext_half(b);
    end else begin
      ea = sext_full(a);
      eb = sext_full(b);
    end
    return ea * eb;
  endfunction

  // Long-form clamp: only the upper bits of the high word move.
  function automatic acc_t clamp_long(input acc_t sum);
    acc_t r;
    r = sum;
    if (sum[MAC_AW-1]) begin
      r[MAC_AW-1 -: MAC_HW] = '1;
    end else begin
      r[MAC_AW-1 -: (MAC_HW+1)] = '0;
    end
    return r;
  endfunction

  // Word-form clamp: signed 32-bit range, overflow marks the high word with 1.
  function automatic acc_t clamp_word(input acc_t sum);
    acc_t r;
    if (sum > WORD_MAX) begin
      r = WORD_POS_CLAMP;
    end else if (sum < WORD_MIN) begin
      r = WORD_NEG_CLAMP;
    end else begin
      r = sum;
    end
    return r;
  endfunction

  function automatic acc_t mac_writeback(input mac_mode_e m, input logic sat, input acc_t sum);
    acc_t r;
    if (!sat) begin
      r = sum;
    end else if (m == MODE_WORD) begin
      r = clamp_word(sum);
    end else begin
      r = clamp_long(sum);
    end
    return r;
  endfunction

endpackage

// File: rtl/sat_mac_ctrl.sv
module sat_mac_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic acc_clear,
  input  logic stage_busy,
  input  logic upd_fire,
  output logic accept,
  output logic done_q
);

  // A start is taken only when no product waits and no clear is present.
  assign accept = op_start && !acc_clear && !stage_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= upd_fire;
    end
  end

endmodule

// File: rtl/sat_mac_mulstage.sv
module sat_mac_mulstage
  import sat_mac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   acc_clear,
  input  logic   op_word,
  input  logic   op_sat,
  input  word_t  op_a,
  input  word_t  op_b,
  output stage_t stage
);

  mac_mode_e mode_in;
  acc_t      prod_in;

  assign mode_in = op_word ? MODE_WORD : MODE_LONG;
  assign prod_in = mac_product(mode_in, op_a, op_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (acc_clear) begin
      stage.valid <= 1'b0;
    end else if (accept) begin
      stage.valid <= 1'b1;
      stage.mode  <= mode_in;
      stage.sat   <= op_sat;
      stage.prod  <= prod_in;
    end else begin
      stage.valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sat_mac_accum.sv
module sat_mac_accum
  import sat_mac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   acc_clear,
  input  stage_t stage,
  output logic   upd_fire,
  output acc_t   acc_q
);

  acc_t sum;
  acc_t next_acc;

  assign upd_fire = stage.valid && !acc_clear;
  assign sum      = acc_q + stage.prod;
  assign next_acc = mac_writeback(stage.mode, stage.sat, sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_clear) begin
      acc_q <= '0;
    end else if (upd_fire) begin
      acc_q <= next_acc;
    end
  end

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_start,
  input  logic        op_word,
  input  logic        op_sat,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        acc_clear,
  output logic [31:0] acc_hi,
  output logic [31:0] acc_lo,
  output logic        op_done
);

  stage_t    stage_w;
  logic      accept_w;
  logic      fire_w;
  acc_t      acc_w;
  logic      stage_word_w;
  logic      stage_sat_w;

  assign stage_word_w = (stage_w.mode == MODE_WORD);
  assign stage_sat_w  = stage_w.sat;

  sat_mac_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .acc_clear  (acc_clear),
    .stage_busy (stage_w.valid),
    .upd_fire   (fire_w),
    .accept     (accept_w),
    .done_q     (op_done)
  );

  sat_mac_mulstage u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_w),
    .acc_clear (acc_clear),
    .op_word   (op_word),
    .op_sat    (op_sat),
    .op_a      (op_a),
    .op_b      (op_b),
    .stage     (stage_w)
  );

  sat_mac_accum u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_clear (acc_clear),
    .stage     (stage_w),
    .upd_fire  (fire_w),
    .acc_q     (acc_w)
  );

  assign acc_hi = acc_w[MAC_AW-1:MAC_DW];
  assign acc_lo = acc_w[MAC_DW-1:0];

endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_clear,
  input logic [31:0] acc_hi,
  input logic [31:0] acc_lo,
  input logic        op_done,
  input logic        accept_w,
  input logic        fire_w,
  input logic        stage_word_w,
  input logic        stage_sat_w
);

  // R7: an accepted start not cancelled by clear produces a done pulse.
  assert_done_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept_w) && !acc_clear) |=> op_done);

  // R7: done lasts one cycle.
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R8: no second acceptance in the cycle after one.
  assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !accept_w);

  // R9: clear leaves a zero accumulator and no done.
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |=> (acc_hi == 32'd0 && acc_lo == 32'd0 && !op_done));

  // R10: the value only moves on an accumulate or a clear.
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clear |=> (op_done || ($stable(acc_hi) && $stable(acc_lo))));

  // R4: long-form saturated high word has its upper bits all copies of one sign.
  assert_long_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && !stage_word_w && stage_sat_w) |=>
      (acc_hi[31:16] == 16'hFFFF || acc_hi[31:15] == 17'd0));

  // R5 R6: word-form saturated result is a 32-bit value or a marked clamp.
  assert_word_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && stage_word_w && stage_sat_w) |=>
      (acc_hi == {32{acc_lo[31]}} ||
       (acc_hi == 32'd1 && (acc_lo == 32'h7FFFFFFF || acc_lo == 32'h80000000))));

endmodule

bind sat_mac_unit sat_mac_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_clear    (acc_clear),
  .acc_hi       (acc_hi),
  .acc_lo       (acc_lo),
  .op_done      (op_done),
  .accept_w     (accept_w),
  .fire_w       (fire_w),
  .stage_word_w (stage_word_w),
  .stage_sat_w  (stage_sat_w)
);

// File: tb/sat_mac_unit_tb.sv
`timescale 1ns/1ps
module sat_mac_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic        op_word = 1'b0;
  logic        op_sat = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        acc_clear = 1'b0;
  logic [31:0] acc_hi;
  logic [31:0] acc_lo;
  logic        op_done;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  sat_mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_word(op_word),
    .op_sat(op_sat), .op_a(op_a), .op_b(op_b), .acc_clear(acc_clear),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .op_done(op_done)
  );

  // Behavioural reference: signed 64-bit arithmetic.
  longint m_acc = 0;
  longint m_prod = 0;
  bit     m_pend = 0;
  bit     m_word = 0;
  bit     m_s = 0;
  bit     m_done = 0;

  function automatic longint ref_prod(bit w, logic [31:0] a, logic [31:0] b);
    longint x;
    longint y;
    if (w) begin
      x = longint'($signed(a[15:0]));
      y = longint'($signed(b[15:0]));
    end else begin
      x = longint'($signed(a));
      y = longint'($signed(b));
    end
    return x * y;
  endfunction

  function automatic longint ref_next(longint acc, longint p, bit w, bit s);
    longint sum;
    sum = acc + p;
    if (!s) return sum;
    if (w) begin
      if (sum > 64'sd2147483647) return 64'sh0000_0001_7FFF_FFFF;
      if (sum < -64'sd2147483648) return 64'sh0000_0001_8000_0000;
      return sum;
    end
    if (sum < 0) return sum | 64'shFFFF_0000_0000_0000;
    return sum & 64'sh0000_7FFF_FFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_pend = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (acc_clear) begin
        m_acc = 0;
        m_pend = 0;
      end else if (m_pend) begin
        m_acc = ref_next(m_acc, m_prod, m_word, m_s);
        m_done = 1;
        m_pend = 0;
      end else if (op_start) begin
        m_prod = ref_prod(op_word, op_a, op_b);
        m_word = op_word;
        m_s = op_sat;
        m_pend = 1;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    checks++;
    if ({acc_hi, acc_lo} !== m_acc || op_done !== m_done) begin
      errors++;
      $display("FAIL %s: acc=%h done=%b expected acc=%h done=%b",
               cur_req, {acc_hi, acc_lo}, op_done, m_acc, m_done);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_op(bit w, bit s, logic [31:0] a, logic [31:0] b);
    op_start = 1; op_word = w; op_sat = s; op_a = a; op_b = b;
    @(negedge clk);
    op_start = 0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    acc_clear = 1;
    @(negedge clk);
    acc_clear = 0;
  endtask

  task automatic expect_acc(string tag, logic [63:0] exp);
    checks++;
    if ({acc_hi, acc_lo} !== exp) begin
      errors++;
      $display("FAIL %s: acc=%h expected %h", tag, {acc_hi, acc_lo}, exp);
    end
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(3);
    expect_acc("R1", 64'h0);
    rst_n = 1;
    idle(2);

    cur_req = "R2";
    do_op(0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF);
    expect_acc("R2", 64'h3FFFFFFF_00000001);
    do_op(0, 0, 32'hFFFFFFFF, 32'h00000003);
    expect_acc("R2", 64'h3FFFFFFE_FFFFFFFE);

    cur_req = "R4";
    do_op(0, 1, 32'h0, 32'h0);
    expect_acc("R4", 64'h00007FFE_FFFFFFFE);
    do_clear();
    do_op(0, 1, 32'h00000001, 32'hFFFFFFFF);
    expect_acc("R4", 64'hFFFFFFFF_FFFFFFFF);
    do_op(0, 1, 32'h00000001, 32'h00000001);
    expect_acc("R4", 64'h0);

    cur_req = "R3";
    do_op(1, 0, 32'h12348000, 32'hABCD8000);
    expect_acc("R3", 64'h00000000_40000000);

    cur_req = "R5";
    do_op(1, 1, 32'h00008000, 32'h00008000);
    expect_acc("R5", 64'h00000001_7FFFFFFF);

    cur_req = "R6";
    do_clear();
    do_op(1, 0, 32'h00008000, 32'h00008000);
    do_op(1, 0, 32'h00008000, 32'h00008001);
    do_op(1, 1, 32'h00000001, 32'h00007FFF);
    expect_acc("R6", 64'h00000000_7FFFFFFF);
    cur_req = "R5";
    do_op(1, 1, 32'h00000001, 32'h00000001);
    expect_acc("R5", 64'h00000001_7FFFFFFF);

    cur_req = "R6";
    do_clear();
    do_op(1, 1, 32'h00008000, 32'h00007FFF);
    do_op(1, 1, 32'h00008000, 32'h00007FFF);
    do_op(1, 1, 32'h00008000, 32'h00000002);
    expect_acc("R6", 64'hFFFFFFFF_80000000);
    do_op(1, 1, 32'h0000FFFF, 32'h00000001);
    expect_acc("R6", 64'h00000001_80000000);

    cur_req = "R8";
    do_clear();
    op_start = 1; op_word = 0; op_sat = 0; op_a = 32'd5; op_b = 32'd7;
    @(negedge clk);
    op_a = 32'd100; op_b = 32'd100;
    @(negedge clk);
    op_start = 0;
    idle(2);
    expect_acc("R8", 64'd35);

    cur_req = "R9";
    op_start = 1; acc_clear = 1; op_a = 32'd9; op_b = 32'd9;
    @(negedge clk);
    op_start = 0; acc_clear = 0;
    idle(3);
    expect_acc("R9", 64'd0);
    op_start = 1; op_a = 32'd3; op_b = 32'd3;
    @(negedge clk);
    op_start = 0; acc_clear = 1;
    @(negedge clk);
    acc_clear = 0;
    idle(3);
    expect_acc("R9", 64'd0);

    cur_req = "R7 R10";
    for (int i = 0; i < 3000; i++) begin
      op_start  = ($urandom % 3) == 0;
      acc_clear = ($urandom % 41) == 0;
      op_word   = $urandom % 2;
      op_sat    = $urandom % 2;
      case ($urandom % 4)
        0: begin op_a = 32'h7FFFFFFF; op_b = $urandom; end
        1: begin op_a = 32'h80000000 | $urandom; op_b = 32'h00008000; end
        2: begin op_a = $urandom % 8 - 4; op_b = $urandom % 8 - 4; end
        default: begin op_a = $urandom; op_b = $urandom; end
      endcase
      @(negedge clk);
    end
    op_start = 0; acc_clear = 0;
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule